// File: doc/BRIEF.md
# Intra 8x8 Edge Smoothing Predictor

This block forms the predicted pixels of one 8x8 luma block for a single intra prediction mode, given the already filtered neighbour edge of that block. The edge arrives as a flat 36-byte vector: left column, top-left corner, top row and top-right extension. The mode is a 4-bit number. Every directional mode draws its samples from one of two derived edge vectors, both built inside the block: the two-tap averages and the three-tap smoothed values. A fixed per-row gather pattern then picks the samples for each mode, so no mode has arithmetic of its own.

A one-cycle `start` pulse latches the edge and the mode. The eight rows of the prediction then leave a registered output, one row per cycle, with a valid strobe and a row index. A cost evaluator or a reconstruction path would consume the rows as they arrive. A mode number outside the nine defined modes yields a zero block and raises an error flag along with those rows.

Top module: `i8_edge_pred`

## Requirements
- R1: Synchronous active-low reset clears `busy`, `row_valid` and `mode_err`, also in the middle of a block.
- R2: When `start` is sampled high while `busy` is low, `mode` and `edge_in` are captured. `row_valid` is then high for exactly 8 consecutive cycles, starting one cycle after the capture edge, with `row_idx` counting 0 to 7. Column c of a row sits in bits [8c+7:8c].
- R3: A `start` sampled while `busy` is high is ignored. The running block finishes with its captured data and mode, and no extra block follows.
- R4: Edge layout: left pixel of row i is byte 14−i, the corner is byte 15 and top pixel j is byte 16+j (j up to 15). Byte k sits in `edge_in` bits [8k+7:8k]. Mode 0 (vertical) copies top pixel c to every row. Mode 1 (horizontal) copies left pixel r across row r.
- R5: Mode 2 fills the block with (sum of 8 left + sum of 8 top + 8) >> 4.
- R6: Mode 3 (down-left) gives pixel (r,c) = t3(T[r+c], T[r+c+1], T[r+c+2]), where t3(a,b,c) = (a+2b+c+2)>>2. Pixel (7,7) uses (T14 + 3·T15 + 2)>>2.
- R7: Mode 4 (down-right) gives diagonal pixels t3(L0, corner, T0). Above the diagonal it runs three-tap along the top edge, below it along the left edge.
- R8: Mode 5 (vertical-right): with z = 2c−r, even z ≥ 0 gives two-tap t2(a,b) = (a+b+1)>>1 of top pixels, odd z gives three-tap, and z < −1 gives three-tap down the left column.
- R9: Mode 6 (horizontal-down) is the transposed counterpart: with z = 2r−c, even z ≥ 0 gives two-tap of left pixels, odd z gives three-tap, and z < −1 gives three-tap along the top.
- R10: Mode 7 (vertical-left): even rows 2k use t2(T[c+k], T[c+k+1]); odd rows 2k+1 use t3(T[c+k], T[c+k+1], T[c+k+2]).
- R11: Mode 8 (horizontal-up): with z = c+2r, z ≤ 12 alternates two-tap and three-tap down the left column. z = 13 gives (L6 + 3·L7 + 2)>>2, and z > 13 repeats L7 unfiltered.
- R12: A mode above 8 outputs all-zero rows with `mode_err` high on each of them. `mode_err` is low for modes 0 to 8.
- R13: Bytes 0 to 6 and 32 to 35 of `edge_in` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a block; ignored while busy |
| mode | input | 4 | Prediction mode, 0 to 8 defined |
| edge_in | input | 36*PIX_W | Filtered neighbour edge, byte k at bits [8k+7:8k] |
| busy | output | 1 | Block in progress |
| row_valid | output | 1 | `row_pix` holds a predicted row |
| row_idx | output | 3 | Row number of `row_pix` |
| row_pix | output | 8*PIX_W | Eight predicted pixels, column 0 lowest |
| mode_err | output | 1 | Current row belongs to an undefined mode |

## Verification
Each of the nine modes runs on four edge patterns, and each pattern exposes a different kind of fault. A ramp shows whether the gather picks the wrong byte or the wrong row offset. A scrambled pattern catches mixed-up left and top sources. All-ones checks for carry loss in the DC sum and the tap adders. Alternating 0 and 255 bytes make every pair sum odd, so a wrong rounding or a wrong parity correction in the three-tap path shows at once. Separate runs vary only the unused edge bytes, issue a start in the middle of a block, reset in the middle of a block, and send undefined modes.

// File: rtl/i8p_pkg.sv
// Shared constants and types for the intra 8x8 edge predictor.
// Assumes 8x8 blocks and a 36-entry edge vector; byte positions are fixed
// by the edge layout that the gather patterns decode.
package i8p_pkg;

    localparam int BLK        = 8;
    localparam int ROW_W      = $clog2(BLK);
    localparam int EDGE_BYTES = 36;
    localparam int POS_FIRST  = 14 - (BLK - 1);   // bottom-left pixel
    localparam int POS_LEFT0  = 14;               // left pixel of row 0
    localparam int POS_CORNER = 15;               // top-left pixel
    localparam int POS_TOP0   = 16;               // top pixel 0
    localparam int POS_LAST   = POS_TOP0 + 2*BLK - 1;
    localparam int HU_LIMIT   = 2*BLK - 3;        // last filtered index of mode 8
    localparam int MODE_LAST  = 8;

    typedef enum logic [3:0] {
        M_VERT    = 4'd0,
        M_HORZ    = 4'd1,
        M_MEAN    = 4'd2,
        M_DIAG_DL = 4'd3,
        M_DIAG_DR = 4'd4,
        M_VERT_R  = 4'd5,
        M_HORZ_D  = 4'd6,
        M_VERT_L  = 4'd7,
        M_HORZ_U  = 4'd8
    } pmode_e;

    typedef enum logic [2:0] {
        S_ZERO,
        S_RAW,
        S_P2,
        S_P3,
        S_DC
    } src_e;

endpackage

// File: rtl/i8p_taps.sv
// Derived edge vectors: two-tap average between byte k and k+1, three-tap
// smoothed value centred on byte k, and the DC mean of left and top pixels.
// Assumes the edge outside bytes POS_FIRST..POS_LAST is unused; the
// three-tap ends repeat the end pixel. Purely combinational.
module i8p_taps
    import i8p_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic [PIX_W-1:0] edge_b [EDGE_BYTES],
    output logic [PIX_W-1:0] p2     [EDGE_BYTES],
    output logic [PIX_W-1:0] p3     [EDGE_BYTES],
    output logic [PIX_W-1:0] dc
);

    localparam logic [PIX_W:0] ONE = {{PIX_W{1'b0}}, 1'b1};

    for (genvar k = 0; k < EDGE_BYTES; k++) begin : g_tap
        if (k >= POS_FIRST && k <= POS_LAST) begin : g_on
            localparam int KL = (k == POS_FIRST) ? k : k - 1;
            localparam int KR = (k == POS_LAST)  ? k : k + 1;
            logic [PIX_W:0]   s_out, s_mid;
            logic [PIX_W-1:0] avg_out, lo_out;
            // outer-pair average rounded up, then corrected down on odd sum
            assign s_out   = {1'b0, edge_b[KL]} + {1'b0, edge_b[KR]} + ONE;
            assign avg_out = s_out[PIX_W:1];
            assign lo_out  = avg_out - {{(PIX_W-1){1'b0}}, edge_b[KL][0] ^ edge_b[KR][0]};
            // rounded-up average of the centre and the corrected outer mean
            assign s_mid   = {1'b0, lo_out} + {1'b0, edge_b[k]} + ONE;
            assign p3[k]   = s_mid[PIX_W:1];
            if (k < POS_LAST) begin : g_two
                logic [PIX_W:0] s_pair;
                // plain rounded average of adjacent bytes
                assign s_pair = {1'b0, edge_b[k]} + {1'b0, edge_b[k+1]} + ONE;
                assign p2[k]  = s_pair[PIX_W:1];
            end else begin : g_two_off
                assign p2[k] = '0;
            end
        end else begin : g_off
            assign p2[k] = '0;
            assign p3[k] = '0;
        end
    end

    // DC: sum of eight left and eight top pixels, rounded, divided by 16
    always_comb begin : p_dc
        logic [PIX_W+4:0] acc;
        acc = (PIX_W+5)'(BLK);
        for (int i = 0; i < BLK; i++) begin
            acc = acc + {5'b0, edge_b[POS_LEFT0-i]} + {5'b0, edge_b[POS_TOP0+i]};
        end
        dc = acc[PIX_W+3:4];
    end

endmodule

// File: rtl/i8p_row_gather.sv
// Per-column source selection: for the given mode and row, each column picks
// one byte from the raw edge, the two-tap vector, the three-tap vector or the
// DC value. Assumes mode values above MODE_LAST select zero. Combinational.
module i8p_row_gather
    import i8p_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic [3:0]           mode,
    input  logic [ROW_W-1:0]     row,
    input  logic [PIX_W-1:0]     raw [EDGE_BYTES],
    input  logic [PIX_W-1:0]     p2  [EDGE_BYTES],
    input  logic [PIX_W-1:0]     p3  [EDGE_BYTES],
    input  logic [PIX_W-1:0]     dc,
    output logic [BLK*PIX_W-1:0] row_out
);

    for (genvar c = 0; c < BLK; c++) begin : g_col
        src_e             src;
        logic [5:0]       pos;
        logic [PIX_W-1:0] pix;

        // decide which vector and which byte feeds column c
        always_comb begin : p_pick
            int rr, z, h, a, k;
            rr  = int'(row);
            z   = 0;
            h   = 0;
            a   = 0;
            k   = POS_FIRST;
            src = S_ZERO;
            case (mode)
                M_VERT:    begin src = S_RAW; k = POS_TOP0 + c; end
                M_HORZ:    begin src = S_RAW; k = POS_LEFT0 - rr; end
                M_MEAN:    src = S_DC;
                M_DIAG_DL: begin src = S_P3; k = POS_TOP0 + 1 + rr + c; end
                M_DIAG_DR: begin src = S_P3; k = POS_CORNER + c - rr; end
                M_VERT_R: begin
                    z = 2*c - rr;
                    h = rr >> 1;
                    if (z >= -1) begin
                        k   = POS_CORNER + c - h;
                        src = ((z & 1) != 0) ? S_P3 : S_P2;
                    end else begin
                        k   = POS_TOP0 + 2*c - rr;
                        src = S_P3;
                    end
                end
                M_HORZ_D: begin
                    z = 2*rr - c;
                    h = c >> 1;
                    a = rr - h;
                    if (z >= -1) begin
                        if ((z & 1) != 0) begin src = S_P3; k = POS_CORNER - a; end
                        else              begin src = S_P2; k = POS_LEFT0 - a;  end
                    end else begin
                        k   = POS_LEFT0 + c - 2*rr;
                        src = S_P3;
                    end
                end
                M_VERT_L: begin
                    h = rr >> 1;
                    if ((rr & 1) != 0) begin src = S_P3; k = POS_TOP0 + 1 + c + h; end
                    else               begin src = S_P2; k = POS_TOP0 + c + h;     end
                end
                M_HORZ_U: begin
                    z = c + 2*rr;
                    a = rr + (c >> 1);
                    if (z > HU_LIMIT) begin
                        src = S_RAW;
                        k   = POS_FIRST;
                    end else begin
                        k   = POS_LEFT0 - 1 - a;
                        src = ((z & 1) != 0) ? S_P3 : S_P2;
                    end
                end
                default:   src = S_ZERO;
            endcase
            pos = 6'(k);
        end

        // fetch the chosen byte
        always_comb begin : p_fetch
            case (src)
                S_RAW:   pix = raw[pos];
                S_P2:    pix = p2[pos];
                S_P3:    pix = p3[pos];
                S_DC:    pix = dc;
                default: pix = '0;
            endcase
        end

        assign row_out[c*PIX_W +: PIX_W] = pix;
    end

endmodule

// File: rtl/i8_edge_pred.sv
// Intra 8x8 predictor top: captures edge and mode on an accepted start,
// then registers one predicted row per cycle for BLK cycles.
// Assumes start is ignored while a block is in progress; the edge capture
// register is not reset since it is only read while busy.
module i8_edge_pred
    import i8p_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [3:0]                  mode,
    input  logic [EDGE_BYTES*PIX_W-1:0] edge_in,
    output logic                        busy,
    output logic                        row_valid,
    output logic [ROW_W-1:0]            row_idx,
    output logic [BLK*PIX_W-1:0]        row_pix,
    output logic                        mode_err
);

    logic [PIX_W-1:0]     edge_q [EDGE_BYTES];
    logic [PIX_W-1:0]     p2     [EDGE_BYTES];
    logic [PIX_W-1:0]     p3     [EDGE_BYTES];
    logic [PIX_W-1:0]     dc;
    logic [3:0]           mode_q;
    logic                 busy_q;
    logic [ROW_W-1:0]     row_q;
    logic                 take;
    logic                 bad_mode;
    logic [BLK*PIX_W-1:0] row_next;

    assign take     = start && !busy_q;
    assign bad_mode = mode_q > 4'(MODE_LAST);
    assign busy     = busy_q;

    // sequence control: row counter runs BLK cycles after an accepted start
    always_ff @(posedge clk) begin : p_ctrl
        if (!rst_n) begin
            busy_q <= 1'b0;
            row_q  <= '0;
        end else if (take) begin
            busy_q <= 1'b1;
            row_q  <= '0;
        end else if (busy_q) begin
            row_q <= row_q + 1'b1;
            if (row_q == ROW_W'(BLK-1)) busy_q <= 1'b0;
        end
    end

    // capture edge bytes and mode when a block is accepted
    for (genvar k = 0; k < EDGE_BYTES; k++) begin : g_cap
        always_ff @(posedge clk) begin : p_cap
            if (take) edge_q[k] <= edge_in[k*PIX_W +: PIX_W];
        end
    end

    // capture the mode number with the edge
    always_ff @(posedge clk) begin : p_mode
        if (take) mode_q <= mode;
    end

    i8p_taps #(.PIX_W(PIX_W)) u_taps (
        .edge_b (edge_q),
        .p2     (p2),
        .p3     (p3),
        .dc     (dc)
    );

    i8p_row_gather #(.PIX_W(PIX_W)) u_gather (
        .mode    (mode_q),
        .row     (row_q),
        .raw     (edge_q),
        .p2      (p2),
        .p3      (p3),
        .dc      (dc),
        .row_out (row_next)
    );

    // output register: one row, its index and the error flag per busy cycle
    always_ff @(posedge clk) begin : p_out
        if (!rst_n) begin
            row_valid <= 1'b0;
            row_idx   <= '0;
            row_pix   <= '0;
            mode_err  <= 1'b0;
        end else begin
            row_valid <= busy_q;
            if (busy_q) begin
                row_idx  <= row_q;
                row_pix  <= row_next;
                mode_err <= bad_mode;
            end else begin
                mode_err <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/i8p_chk.sv
// Protocol checker for the intra 8x8 predictor, bound to the top module.
// Assumes the reset is synchronous and active low.
module i8p_chk
    import i8p_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic                 busy,
    input logic                 row_valid,
    input logic [ROW_W-1:0]     row_idx,
    input logic [BLK*PIX_W-1:0] row_pix,
    input logic                 mode_err
);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !row_valid && !mode_err));

    p_start_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_first_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(row_valid) |-> (row_idx == '0));

    p_row_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (row_valid && row_idx != ROW_W'(BLK-1)) |=>
            (row_valid && row_idx == $past(row_idx) + 1'b1));

    p_last_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (row_valid && row_idx == ROW_W'(BLK-1)) |=> !row_valid);

    p_busy_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (row_valid && row_idx != ROW_W'(BLK-1)) |-> busy);

    p_err_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> (row_valid && row_pix == '0));

endmodule

bind i8_edge_pred i8p_chk #(.PIX_W(PIX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .row_valid (row_valid),
    .row_idx   (row_idx),
    .row_pix   (row_pix),
    .mode_err  (mode_err)
);

// File: tb/sim_i8_edge_pred.sv
`timescale 1ns/1ps
module sim_i8_edge_pred;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         start;
    logic [3:0]   mode;
    logic [287:0] edge_in;
    logic         busy;
    logic         row_valid;
    logic [2:0]   row_idx;
    logic [63:0]  row_pix;
    logic         mode_err;

    int checks = 0;
    int fails  = 0;
    logic [7:0] eb [36];

    always #4 clk = ~clk;

    i8_edge_pred u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .edge_in(edge_in),
        .busy(busy), .row_valid(row_valid), .row_idx(row_idx), .row_pix(row_pix),
        .mode_err(mode_err)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // reference edge accessors, with corner and end replication
    function automatic int lp(int i);
        if (i < 0) return int'(eb[15]);
        if (i > 7) i = 7;
        return int'(eb[14-i]);
    endfunction
    function automatic int tp(int j);
        if (j < 0) return int'(eb[15]);
        if (j > 15) j = 15;
        return int'(eb[16+j]);
    endfunction
    function automatic int t2(int a, int b);
        return (a + b + 1) >> 1;
    endfunction
    function automatic int t3(int a, int b, int c);
        return (a + 2*b + c + 2) >> 2;
    endfunction

    function automatic int ref_pix(int m, int r, int c);
        int z, s;
        case (m)
            0: return tp(c);
            1: return lp(r);
            2: begin
                s = 8;
                for (int i = 0; i < 8; i++) s += lp(i) + tp(i);
                return s >> 4;
            end
            3: if (r == 7 && c == 7) return (tp(14) + 3*tp(15) + 2) >> 2;
               else return t3(tp(r+c), tp(r+c+1), tp(r+c+2));
            4: if (c > r) return t3(tp(c-r-2), tp(c-r-1), tp(c-r));
               else if (c < r) return t3(lp(r-c-2), lp(r-c-1), lp(r-c));
               else return t3(lp(0), int'(eb[15]), tp(0));
            5: begin
                z = 2*c - r;
                if (z >= 0 && z % 2 == 0) return t2(tp(c-(r>>1)-1), tp(c-(r>>1)));
                else if (z > 0) return t3(tp(c-(r>>1)-2), tp(c-(r>>1)-1), tp(c-(r>>1)));
                else if (z == -1) return t3(lp(0), int'(eb[15]), tp(0));
                else return t3(lp(r-2*c-1), lp(r-2*c-2), lp(r-2*c-3));
            end
            6: begin
                z = 2*r - c;
                if (z >= 0 && z % 2 == 0) return t2(lp(r-(c>>1)-1), lp(r-(c>>1)));
                else if (z > 0) return t3(lp(r-(c>>1)-2), lp(r-(c>>1)-1), lp(r-(c>>1)));
                else if (z == -1) return t3(lp(0), int'(eb[15]), tp(0));
                else return t3(tp(c-2*r-1), tp(c-2*r-2), tp(c-2*r-3));
            end
            7: if (r % 2 == 0) return t2(tp(c+(r>>1)), tp(c+(r>>1)+1));
               else return t3(tp(c+(r>>1)), tp(c+(r>>1)+1), tp(c+(r>>1)+2));
            8: begin
                z = c + 2*r;
                if (z > 13) return lp(7);
                if (z == 13) return (lp(6) + 3*lp(7) + 2) >> 2;
                if (z % 2 == 0) return t2(lp(r+(c>>1)), lp(r+(c>>1)+1));
                return t3(lp(r+(c>>1)), lp(r+(c>>1)+1), lp(r+(c>>1)+2));
            end
            default: return 0;
        endcase
    endfunction

    function automatic logic [63:0] ref_row(int m, int r);
        logic [63:0] v;
        for (int c = 0; c < 8; c++) v[c*8 +: 8] = 8'(ref_pix(m, r, c));
        return v;
    endfunction

    function automatic logic [287:0] pack_edge();
        logic [287:0] p;
        for (int k = 0; k < 36; k++) p[k*8 +: 8] = eb[k];
        return p;
    endfunction

    task automatic fill(input int kind, input int seed);
        for (int k = 0; k < 36; k++) begin
            case (kind)
                0: eb[k] = 8'(k*7 + 3);
                1: eb[k] = 8'(k*73 + seed*29 + k*k*5);
                2: eb[k] = 8'hFF;
                default: eb[k] = (k % 2 == 1) ? 8'hFF : 8'h00;
            endcase
        end
    endtask

    // one complete block for mode m, checked row by row against the model
    task automatic run_mode(input int m, input string req);
        @(negedge clk);
        mode = 4'(m); edge_in = pack_edge(); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int r = 0; r < 8; r++) begin
            @(negedge clk);
            chk(row_valid === 1'b1 && row_idx === 3'(r), "R2 row strobe/index",
                {60'd0, row_valid, row_idx}, {60'd0, 1'b1, 3'(r)});
            chk(row_pix === ref_row(m, r), req, row_pix, ref_row(m, r));
            chk(mode_err === (m > 8), "R12 error flag", {63'd0, mode_err}, {63'd0, m > 8});
        end
        @(negedge clk);
        chk(row_valid === 1'b0, "R2 exactly eight rows", {63'd0, row_valid}, 64'd0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; start = 1'b0; mode = '0; edge_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(busy === 1'b0 && row_valid === 1'b0 && mode_err === 1'b0, "R1 reset state",
            {61'd0, busy, row_valid, mode_err}, 64'd0);
    endtask

    task automatic t_modes();
        for (int kind = 0; kind < 4; kind++) begin
            fill(kind, kind + 5);
            run_mode(0, "R4 vertical");
            run_mode(1, "R4 horizontal");
            run_mode(2, "R5 dc");
            run_mode(3, "R6 down-left");
            run_mode(4, "R7 down-right");
            run_mode(5, "R8 vertical-right");
            run_mode(6, "R9 horizontal-down");
            run_mode(7, "R10 vertical-left");
            run_mode(8, "R11 horizontal-up");
        end
    endtask

    task automatic t_bad_mode();
        fill(1, 3);
        run_mode(9, "R12 zero block");
        run_mode(15, "R12 zero block");
    endtask

    // R13: only the unused bytes change between runs; model never reads them
    task automatic t_unused();
        for (int v = 0; v < 2; v++) begin
            fill(1, 11);
            for (int k = 0; k < 7; k++) eb[k] = 8'(v * 200 + k);
            for (int k = 32; k < 36; k++) eb[k] = 8'(v * 150 + 91 * k);
            run_mode(3, "R13 unused bytes, down-left");
            run_mode(8, "R13 unused bytes, horizontal-up");
        end
    endtask

    // R3: a start with new mode and edge while busy leaves the block unchanged
    task automatic t_busy_start();
        fill(0, 0);
        @(negedge clk);
        mode = 4'd6; edge_in = pack_edge(); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int r = 0; r < 8; r++) begin
            @(negedge clk);
            chk(row_valid === 1'b1 && row_pix === ref_row(6, r), "R3 start while busy",
                row_pix, ref_row(6, r));
            if (r == 2) begin start = 1'b1; mode = 4'd0; edge_in = ~pack_edge(); end
            if (r == 5) start = 1'b0;
        end
        @(negedge clk);
        chk(row_valid === 1'b0 && busy === 1'b0, "R3 no extra block",
            {62'd0, row_valid, busy}, 64'd0);
        @(negedge clk);
        chk(row_valid === 1'b0, "R3 no extra block later", {63'd0, row_valid}, 64'd0);
    endtask

    task automatic t_reset_mid();
        fill(1, 7);
        @(negedge clk);
        mode = 4'd12; edge_in = pack_edge(); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0 && row_valid === 1'b0 && mode_err === 1'b0, "R1 reset mid-block",
            {61'd0, busy, row_valid, mode_err}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(row_valid === 1'b0, "R1 idle after reset", {63'd0, row_valid}, 64'd0);
    endtask

    initial begin
        t_reset();
        t_modes();
        t_bad_mode();
        t_unused();
        t_busy_start();
        t_reset_mid();
        run_mode(4, "R7 down-right after reset");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule